// File: doc/BRIEF.md
# Interrupt Level Priority Arbiter

This block decides which levelled interrupt, if any, a processor core should take next. It merges a vector of sixteen external interrupt level lines with a 32-bit software interrupt register. The register is held inside the block and updated through set, clear and write ports. The merged pending set is compared against the processor's current interrupt level. The block then picks the highest pending level above it and presents a hard interrupt request together with the trap type number for that level.

Two timer bits in the software register are not levels of their own; either of them raises level 14. The block yields to a vector interrupt in progress: while that is busy, nothing changes. It also refuses to stack a new levelled interrupt on top of a saved external-interrupt trap of a higher type. All decisions are registered, so the outputs follow the inputs by exactly one clock.

Top module: `irqarb_top`

## Requirements
- R1: While reset is asserted, and after it is released with no pending input, irqReq is 0, trapType is 0 and softValue is 0.
- R2: Software register update, visible on softValue one clock later: softWrEn loads softData; otherwise softSetEn ORs softData in and then softClrEn removes the bits of softData (clear wins when both are given); with no strobe the value is kept.
- R3: The pending mask is extLevels (bits 15..0) ORed with the software register, with software bits 0 and 16 excluded; if software bit 0 or bit 16 is 1, pending bit 14 is forced to 1.
- R4: While vecBusy is 1, irqReq and trapType keep their values at the next clock.
- R5: When vecBusy is 0 and the 32-bit pending mask is numerically less than (2 << curLevel), the next clock gives irqReq 0 and trapType 0.
- R6: When vecBusy is 0, the mask passes R5 and intEnable is 1, the winner is the highest set pending bit among levels 15 down to curLevel+1. Its type is 0x40 | level. If it is not suppressed (R7) and differs from trapType, the next clock gives irqReq 1 and trapType equal to that type.
- R7: A winner is suppressed, and irqReq and trapType kept, when trapLevel is non-zero, (savedType & 0x1F0) equals 0x40, and savedType is greater than the winner's type.
- R8: If the winner's type equals the current trapType, or no pending bit lies in levels curLevel+1..15 (for example only software bits 17..31 are set), irqReq and trapType are kept.
- R9: When vecBusy is 0, the mask passes R5 and intEnable is 0, the next clock gives irqReq 0 and trapType 0.
- R10: Outputs change only at a rising clock edge, one clock after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extLevels | input | 16 | External interrupt level lines, bit n is level n |
| softSetEn | input | 1 | OR softData into the software register |
| softClrEn | input | 1 | Clear the softData bits in the software register |
| softWrEn | input | 1 | Replace the software register with softData |
| softData | input | 32 | Operand for the software register ports |
| curLevel | input | 4 | Processor current interrupt level |
| intEnable | input | 1 | Global interrupt enable |
| vecBusy | input | 1 | Vector interrupt in progress, freezes arbitration |
| trapLevel | input | 3 | Current trap nesting level |
| savedType | input | 9 | Trap type saved at the current trap level |
| irqReq | output | 1 | Hard interrupt request |
| trapType | output | 9 | Trap type of the requested interrupt, 0 when none |
| softValue | output | 32 | Current software interrupt register |

## Verification
The hardest situation to reach is suppression. It needs an outstanding request and a non-zero trap level. The saved type must lie in the external-interrupt group and be above the new winner. That winner must also differ from the stored type, or the hold would happen anyway. The bench therefore first raises a low level so the stored type is known. It then sweeps the saved type across the group and just outside it, with the trap level at zero and at non-zero values, while a second, higher level competes. A further case reaches the pass-the-threshold-but-no-winner hold. It sets only high software bits at level 15, which needs the full 32-bit compare.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int TRAP_BASE  = 'h40;
  localparam int GROUP_MASK = 'h1F0;
  localparam int TIMER_LEVEL = 14;

  typedef struct packed {
    logic clear;
    logic load;
  } arbStrobe_t;
endpackage

// File: rtl/irqarb_datapath.sv
module irqarb_datapath
  import irqarb_pkg::*;
#(
  parameter int LEVELS = 16,
  parameter int SOFT_W = 32,
  parameter int TT_W   = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [LEVELS-1:0]         extLevels,
  input  logic                      softSetEn,
  input  logic                      softClrEn,
  input  logic                      softWrEn,
  input  logic [SOFT_W-1:0]         softData,
  input  logic [$clog2(LEVELS)-1:0] curLevel,
  input  arbStrobe_t                strobe,
  output logic [SOFT_W-1:0]         softValue,
  output logic [SOFT_W-1:0]         pendMask,
  output logic                      belowLevel,
  output logic                      winFound,
  output logic [TT_W-1:0]           winType,
  output logic                      irqReq,
  output logic [TT_W-1:0]           trapType
);
  localparam int LW = $clog2(LEVELS);
  localparam int TICK_BIT = 0;
  localparam int STICK_BIT = LEVELS;

  logic [SOFT_W-1:0] softReg;
  logic [SOFT_W-1:0] softNext;
  logic [SOFT_W-1:0] softKeep;
  logic [SOFT_W:0]   thresh;
  logic [LW-1:0]     winLevel;

  // software register next value; arbitration looks at it directly
  always_comb begin
    softNext = softReg;
    if (softWrEn) begin
      softNext = softData;
    end else begin
      if (softSetEn) softNext = softNext | softData;
      if (softClrEn) softNext = softNext & ~softData;
    end
  end

  always_comb begin
    softKeep = softNext;
    softKeep[TICK_BIT] = 1'b0;
    softKeep[STICK_BIT] = 1'b0;
    pendMask = softKeep | SOFT_W'(extLevels);
    if (softNext[TICK_BIT] || softNext[STICK_BIT]) pendMask[TIMER_LEVEL] = 1'b1;
  end

  always_comb begin
    thresh = (SOFT_W+1)'(2) << curLevel;
    belowLevel = {1'b0, pendMask} < thresh;
  end

  // ascending scan so the highest qualifying level is left standing
  always_comb begin
    winFound = 1'b0;
    winLevel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (pendMask[i] && (i > int'(curLevel))) begin
        winFound = 1'b1;
        winLevel = LW'(i);
      end
    end
    winType = TT_W'(TRAP_BASE) | TT_W'(winLevel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softReg  <= '0;
      irqReq   <= 1'b0;
      trapType <= '0;
    end else begin
      softReg <= softNext;
      if (strobe.clear) begin
        irqReq   <= 1'b0;
        trapType <= '0;
      end else if (strobe.load) begin
        irqReq   <= 1'b1;
        trapType <= winType;
      end
    end
  end

  assign softValue = softReg;
endmodule

// File: rtl/irqarb_control.sv
module irqarb_control
  import irqarb_pkg::*;
#(
  parameter int TT_W = 9,
  parameter int TL_W = 3
) (
  input  logic            vecBusy,
  input  logic            intEnable,
  input  logic            belowLevel,
  input  logic            winFound,
  input  logic [TT_W-1:0] winType,
  input  logic [TT_W-1:0] trapType,
  input  logic [TL_W-1:0] trapLevel,
  input  logic [TT_W-1:0] savedType,
  output arbStrobe_t      strobe
);
  logic savedInGroup;
  logic suppress;

  always_comb begin
    savedInGroup = (savedType & TT_W'(GROUP_MASK)) == TT_W'(TRAP_BASE);
    suppress = (trapLevel != '0) && savedInGroup && (savedType > winType);
  end

  always_comb begin
    strobe = '0;
    if (!vecBusy) begin
      if (belowLevel || !intEnable) begin
        strobe.clear = 1'b1;
      end else if (winFound && !suppress && (winType != trapType)) begin
        strobe.load = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqarb_top.sv
module irqarb_top
  import irqarb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] extLevels,
  input  logic        softSetEn,
  input  logic        softClrEn,
  input  logic        softWrEn,
  input  logic [31:0] softData,
  input  logic [3:0]  curLevel,
  input  logic        intEnable,
  input  logic        vecBusy,
  input  logic [2:0]  trapLevel,
  input  logic [8:0]  savedType,
  output logic        irqReq,
  output logic [8:0]  trapType,
  output logic [31:0] softValue
);
  localparam int LEVELS = 16;
  localparam int SOFT_W = 32;
  localparam int TT_W   = 9;
  localparam int TL_W   = 3;

  arbStrobe_t        strobe;
  logic [SOFT_W-1:0] pendMask;
  logic              belowLevel;
  logic              winFound;
  logic [TT_W-1:0]   winType;

  irqarb_datapath #(.LEVELS(LEVELS), .SOFT_W(SOFT_W), .TT_W(TT_W)) u_dp (
    .clk(clk), .rstN(rstN), .extLevels(extLevels),
    .softSetEn(softSetEn), .softClrEn(softClrEn), .softWrEn(softWrEn),
    .softData(softData), .curLevel(curLevel), .strobe(strobe),
    .softValue(softValue), .pendMask(pendMask), .belowLevel(belowLevel),
    .winFound(winFound), .winType(winType), .irqReq(irqReq),
    .trapType(trapType)
  );

  irqarb_control #(.TT_W(TT_W), .TL_W(TL_W)) u_ctl (
    .vecBusy(vecBusy), .intEnable(intEnable), .belowLevel(belowLevel),
    .winFound(winFound), .winType(winType), .trapType(trapType),
    .trapLevel(trapLevel), .savedType(savedType), .strobe(strobe)
  );
endmodule

// File: rtl/irqarb_checker.sv
module irqarb_checker
  import irqarb_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        vecBusy,
  input logic        intEnable,
  input logic        belowLevel,
  input logic        loadStrobe,
  input logic        softSetEn,
  input logic        softClrEn,
  input logic        softWrEn,
  input logic [31:0] softData,
  input logic [31:0] softValue,
  input logic        irqReq,
  input logic [8:0]  trapType
);
  a_r4_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    vecBusy |=> ($stable(irqReq) && $stable(trapType)));

  a_r5_below_drop: assert property (@(posedge clk) disable iff (!rstN)
    (!vecBusy && belowLevel) |=> (!irqReq && trapType == 9'h000));

  a_r9_disabled_drop: assert property (@(posedge clk) disable iff (!rstN)
    (!vecBusy && !intEnable) |=> (!irqReq && trapType == 9'h000));

  a_r6_type_in_group: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((trapType & 9'h1F0) == 9'h040 && trapType[3:0] != 4'h0));

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> trapType == 9'h000);

  a_r8_load_changes: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> (irqReq && trapType != $past(trapType)));

  a_r2_soft_write: assert property (@(posedge clk) disable iff (!rstN)
    softWrEn |=> softValue == $past(softData));

  a_r2_soft_set: assert property (@(posedge clk) disable iff (!rstN)
    (softSetEn && !softClrEn && !softWrEn) |=> softValue == ($past(softValue) | $past(softData)));

  a_r2_soft_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!softSetEn && !softClrEn && !softWrEn) |=> $stable(softValue));
endmodule

bind irqarb_top irqarb_checker u_chk (
  .clk(clk), .rstN(rstN), .vecBusy(vecBusy), .intEnable(intEnable),
  .belowLevel(belowLevel), .loadStrobe(strobe.load),
  .softSetEn(softSetEn), .softClrEn(softClrEn), .softWrEn(softWrEn),
  .softData(softData), .softValue(softValue), .irqReq(irqReq),
  .trapType(trapType)
);

// File: tb/irqarb_top_bench.sv
`timescale 1ns/1ps
module irqarb_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] extLevels = '0;
  logic        softSetEn = 1'b0, softClrEn = 1'b0, softWrEn = 1'b0;
  logic [31:0] softData = '0;
  logic [3:0]  curLevel = '0;
  logic        intEnable = 1'b0, vecBusy = 1'b0;
  logic [2:0]  trapLevel = '0;
  logic [8:0]  savedType = '0;
  logic        irqReq;
  logic [8:0]  trapType;
  logic [31:0] softValue;

  int total = 0, bad = 0, cycles = 0;
  logic        mReq = 1'b0;
  logic [8:0]  mType = '0;
  logic [31:0] mSoft = '0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2 clk = ~clk;

  irqarb_top u_irqarb_top (
    .clk(clk), .rstN(rstN), .extLevels(extLevels), .softSetEn(softSetEn),
    .softClrEn(softClrEn), .softWrEn(softWrEn), .softData(softData),
    .curLevel(curLevel), .intEnable(intEnable), .vecBusy(vecBusy),
    .trapLevel(trapLevel), .savedType(savedType), .irqReq(irqReq),
    .trapType(trapType), .softValue(softValue)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // one clock: called at a falling edge with inputs driven
  task automatic step(input string tagOverride);
    logic [31:0] nSoft, pend;
    logic [32:0] thr;
    logic [8:0]  newT;
    int win;
    string tag;
    nSoft = mSoft;
    if (softWrEn) nSoft = softData;
    else begin
      if (softSetEn) nSoft = nSoft | softData;
      if (softClrEn) nSoft = nSoft & ~softData;
    end
    pend = {16'h0, extLevels} | (nSoft & ~32'h0001_0001);
    if (nSoft[0] || nSoft[16]) pend = pend | 32'h0000_4000;
    thr = 33'd2 << curLevel;
    win = -1;
    for (int i = 15; i > int'(curLevel); i--)
      if (pend[i] && win < 0) win = i;
    if (vecBusy) tag = "R4";
    else if ({1'b0, pend} < thr) begin tag = "R5"; mReq = 1'b0; mType = '0; end
    else if (!intEnable) begin tag = "R9"; mReq = 1'b0; mType = '0; end
    else if (win < 0) tag = "R8";
    else begin
      newT = 9'h040 | 9'(win);
      if (trapLevel != 0 && (savedType & 9'h1F0) == 9'h040 && savedType > newT) tag = "R7";
      else if (newT != mType) begin tag = "R6"; mReq = 1'b1; mType = newT; end
      else tag = "R8";
    end
    if (tagOverride != "") tag = tagOverride;
    #1;
    chk("R10", "early req", {31'h0, irqReq}, {31'h0, u_prevReq});
    chk("R10", "early type", {23'h0, trapType}, {23'h0, u_prevType});
    @(posedge clk);
    @(negedge clk);
    mSoft = nSoft;
    u_prevReq = mReq;
    u_prevType = mType;
    chk(tag, "irqReq", {31'h0, irqReq}, {31'h0, mReq});
    chk(tag, "trapType", {23'h0, trapType}, {23'h0, mType});
    chk("R2", "softValue", softValue, mSoft);
    softSetEn = 1'b0; softClrEn = 1'b0; softWrEn = 1'b0;
  endtask

  logic       u_prevReq = 1'b0;
  logic [8:0] u_prevType = '0;

  task automatic idle();
    extLevels = '0; softWrEn = 1'b1; softData = '0; vecBusy = 1'b0;
    intEnable = 1'b1; trapLevel = '0;
    step("");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset req", {31'h0, irqReq}, 32'h0);
    chk("R1", "reset type", {23'h0, trapType}, 32'h0);
    chk("R1", "reset soft", softValue, 32'h0);
    rstN = 1'b1;
    step("R1");

    // R2 software register ports
    softWrEn = 1'b1; softData = 32'hA5A5_0F0F; step("");
    softSetEn = 1'b1; softData = 32'h0000_F000; step("");
    softClrEn = 1'b1; softData = 32'h0505_0001; step("");
    softSetEn = 1'b1; softClrEn = 1'b1; softData = 32'h0000_0030; step("");
    softWrEn = 1'b1; softSetEn = 1'b1; softData = 32'h0000_0002; step("");
    step("");
    idle();

    // R6 sweep: every current level against every single external level
    for (int c = 0; c < 16; c++) begin
      for (int l = 0; l < 16; l++) begin
        curLevel = 4'(c); extLevels = '0; step("");
        extLevels = 16'(1 << l); step("");
      end
    end
    // R6 highest of several wins
    curLevel = 4'd2; extLevels = 16'h0A18; step("R6");
    extLevels = 16'h0018; step("R6");

    // R3 timer bits and soft levels
    for (int c = 0; c < 14; c++) begin
      curLevel = 4'(c); extLevels = '0;
      softWrEn = 1'b1; softData = 32'h0000_0001; step("R3");
      softWrEn = 1'b1; softData = 32'h0000_0000; step("R3");
      softWrEn = 1'b1; softData = 32'h0001_0000; step("R3");
      softWrEn = 1'b1; softData = 32'h0000_0000; step("R3");
      softWrEn = 1'b1; softData = 32'(1 << (c + 1)); step("R3");
    end
    idle();

    // R7 suppression against a saved type sweep
    for (int tl = 0; tl < 3; tl++) begin
      for (int s = 'h3C; s < 'h54; s++) begin
        curLevel = 4'd1; trapLevel = 3'(tl); savedType = 9'(s);
        extLevels = 16'h0004; step("");
        extLevels = 16'h0104; step("");
        extLevels = 16'h0000; step("");
      end
    end
    savedType = 9'h14F; trapLevel = 3'd1; extLevels = 16'h0004; step("R7");
    extLevels = 16'h0024; step("R7");
    trapLevel = '0; savedType = '0; idle();

    // R8 same winner held, and high soft bits only
    curLevel = 4'd3; extLevels = 16'h0100; step("R8");
    step("R8");
    curLevel = 4'd15; extLevels = '0; softWrEn = 1'b1; softData = 32'h8000_0000; step("R8");
    curLevel = 4'd3; extLevels = 16'h0010; step("R8");
    curLevel = 4'd15; step("R8");
    idle();

    // R4 busy freezes, R9 disable drops
    curLevel = 4'd0; extLevels = 16'h0040; step("R6");
    vecBusy = 1'b1; extLevels = 16'h8000; step("R4");
    extLevels = 16'h0000; step("R4");
    intEnable = 1'b0; step("R4");
    vecBusy = 1'b0; extLevels = 16'h0040; step("R9");
    intEnable = 1'b1; step("R6");
    extLevels = 16'h0000; step("R5");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = nextRand();
      extLevels = 16'(nextRand()) & 16'(nextRand());
      curLevel = r[3:0];
      intEnable = r[7:4] != 4'h0;
      vecBusy = r[11:8] == 4'h0;
      trapLevel = r[14:12];
      savedType = r[15] ? (9'h040 | 9'(r[19:16])) : 9'(r[28:20]);
      softSetEn = r[29]; softClrEn = r[30]; softWrEn = r[31] && r[0];
      softData = nextRand() & nextRand();
      step("");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule